// File: doc/BRIEF.md
# Octal Serial Controller Bus Front End

This block is the shared bus-facing front end of an eight-channel serial controller whose channels are paired into four blocks. It takes single-cycle read and write strobes for four address spaces: register I/O, identification, interrupt acknowledge and byte memory. For the I/O space it splits the 7-bit address into a block index, a channel index and a register offset, and hands channel register accesses to the channel logic through a one-hot select, a register-kind code and read and write strobes. The per-channel registers themselves live outside this block.

It also keeps the interrupt status and interrupt mask registers of all four blocks. The channel logic raises and lowers status bits through per-bit set and clear pulses. The masked status of blocks 0 and 1 drives interrupt line 0, and that of blocks 2 and 3 drives line 1. An interrupt-acknowledge read returns a programmable 8-bit vector. The identification space returns a fixed 12-byte table.

The bus has no back-pressure. Every access is accepted in the cycle of its strobe, and read data appears on `bus_rdata` in the following cycle. The status set and clear inputs are plain pulse inputs with no flow control.

Top module: `octal_uart_frontend`

## Requirements
- R1: An I/O-space access (bus_space 0) whose offset `off = bus_addr[4:0] ^ 1` has bit 3 clear and bit 0 set is a channel register access. It drives `ch_sel` one-hot at channel `bus_addr[6:4]` and `ch_kind = off[2:1]` (0 mode, 1 status/clock-select, 2 command, 3 holding) in the cycle of the strobe. `ch_rd` pulses for read kinds 0, 1 and 3. `ch_wr` pulses for write kinds 0, 2 and 3. `ch_wdata` carries `bus_wdata`. When neither strobe is pulsed, `ch_sel` is 0.
- R2: Writes to the clock-select kind (offsets 0x03/0x13), to offset 0x09 and to offset 0x1B produce no channel strobe and change no status, mask or interrupt line.
- R3: An I/O read returns the selected channel's byte from `ch_rdata[8*ch +: 8]` for channel read kinds, and the block's interrupt status at offset 0x0B. Every other I/O offset, including the command kind, reads as 0.
- R4: Interrupt status bit k of block b (flat index 8*b+k) is set by `isr_set` and cleared by `isr_clr`. When both pulse in the same cycle, the set wins. Bit layout: 0 even-channel transmit ready, 1 even-channel receive ready, 2 even-channel break, 3 counter ready, 4 to 6 the same three flags for the odd channel, 7 input change.
- R5: An I/O write at offset 0x0B loads the mask of block `bus_addr[6:5]` with `bus_wdata`.
- R6: `irq[0]` is high exactly when (status AND mask) is nonzero in block 0 or block 1, and `irq[1]` does the same for blocks 2 and 3. Each line is registered and follows the registers one cycle after they change.
- R7: In the acknowledge space (bus_space 2), reads of address 0 or 2 return the vector and reads of any other address return 0. Writes there are ignored.
- R8: The vector is loaded by a write to address 1 of the identification space (bus_space 1) or of the memory space (bus_space 3). Writes to other addresses of those spaces leave it unchanged. Memory-space reads return 0.
- R9: An identification read at address a returns entry a/2 of the table 0x49 0x50 0x41 0x43 0xF0 0x22 0xA1 0x00 0x00 0x00 0x0C 0xCC for a < 24, and 0 otherwise.
- R10: After reset, `bus_rdata`, `irq`, the vector, every status and every mask are 0.
- R11: Read data is registered: it reflects the access strobed in the previous cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_space | input | 2 | 0 I/O, 1 identification, 2 acknowledge, 3 memory |
| bus_addr | input | 7 | Byte address within the space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| ch_sel | output | 8 | One-hot channel select during a channel access |
| ch_kind | output | 2 | Channel register kind |
| ch_rd | output | 1 | Channel register read strobe |
| ch_wr | output | 1 | Channel register write strobe |
| ch_wdata | output | 8 | Write data for the channel |
| ch_rdata | input | 64 | Read bytes of all eight channels, channel n at [8n+7:8n] |
| isr_set | input | 32 | Status set pulses, block b bit k at index 8b+k |
| isr_clr | input | 32 | Status clear pulses, same indexing |
| irq | output | 2 | Interrupt request lines, active high |

## Verification
The assertions watch, on every cycle, that at most one channel is selected and only during an I/O strobe, that clock-select writes never reach a channel, and that interrupt lines stay low when every mask is clear. They also check that unsupported acknowledge, command and out-of-range identification reads return 0 and that the vector moves only on its two write paths. The bench's sweeps add what no single-cycle property shows. These are the full decode of all 128 I/O addresses against arithmetic expectations, the pairing of blocks onto lines for every status bit, the set-over-clear priority, the contents of the identification table, and the round trip of the vector through both write paths.

// File: rtl/ouf_pkg.sv
package ouf_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int NUM_BLK   = 4;
  localparam int CH_PER_BLK = 2;
  localparam int ID_LEN    = 12;

  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_ID  = 2'd1,
    SP_ACK = 2'd2,
    SP_MEM = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    RK_MODE = 2'd0,
    RK_STAT = 2'd1,
    RK_CMD  = 2'd2,
    RK_HOLD = 2'd3
  } regkind_e;

  localparam logic [4:0] OFF_INT_STATUS = 5'h0B;
endpackage

// File: rtl/ouf_bus_decode.sv
module ouf_bus_decode
  import ouf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CH_W   = 3,
  parameter int BLK_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [4:0]        off,
  output logic [CH_W-1:0]   chan,
  output logic [BLK_W-1:0]  blk,
  output logic              is_chan,
  output regkind_e          kind,
  output logic              is_status
);
  // registers sit at odd byte locations: flip the low address bit
  always_comb begin
    off       = addr[4:0] ^ 5'h01;
    chan      = addr[ADDR_W-1 -: CH_W];
    blk       = addr[ADDR_W-1 -: BLK_W];
    is_chan   = !off[3] && off[0];
    kind      = regkind_e'(off[2:1]);
    is_status = (off == OFF_INT_STATUS);
  end
endmodule

// File: rtl/ouf_irq_block.sv
module ouf_irq_block #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_pulse,
  input  logic [DATA_W-1:0] clr_pulse,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      // a new event in the same cycle as a clear is kept
      status_q <= (status_q & ~clr_pulse) | set_pulse;
      if (mask_we) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/ouf_irq_merge.sv
module ouf_irq_merge #(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 8,
  localparam int NUM_LINES = NUM_BLK / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BLK*DATA_W-1:0] status_flat,
  input  logic [NUM_BLK*DATA_W-1:0] mask_flat,
  output logic [NUM_LINES-1:0]      irq
);
  logic [NUM_BLK-1:0] blk_pend;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_pend
    assign blk_pend[b] = |(status_flat[b*DATA_W +: DATA_W] & mask_flat[b*DATA_W +: DATA_W]);
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[l] <= 1'b0;
      else        irq[l] <= blk_pend[2*l] | blk_pend[2*l+1];
    end
  end
endmodule

// File: rtl/ouf_id_rom.sv
module ouf_id_rom #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int ID_LEN = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [ADDR_W-2:0] idx;

  always_comb begin
    idx  = addr[ADDR_W-1:1];
    data = '0;
    if (int'(idx) < ID_LEN) begin
      case (idx)
        6'd0:    data = 8'h49;
        6'd1:    data = 8'h50;
        6'd2:    data = 8'h41;
        6'd3:    data = 8'h43;
        6'd4:    data = 8'hF0;
        6'd5:    data = 8'h22;
        6'd6:    data = 8'hA1;
        6'd10:   data = 8'h0C;
        6'd11:   data = 8'hCC;
        default: data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/octal_uart_frontend.sv
module octal_uart_frontend
  import ouf_pkg::*;
#(
  parameter int DATA_W  = ouf_pkg::DATA_W,
  parameter int ADDR_W  = ouf_pkg::ADDR_W,
  parameter int NUM_BLK = ouf_pkg::NUM_BLK,
  parameter int ID_LEN  = ouf_pkg::ID_LEN,
  localparam int NUM_CH    = NUM_BLK * CH_PER_BLK,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int NUM_LINES = NUM_BLK / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [1:0]                bus_space,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [NUM_CH-1:0]         ch_sel,
  output logic [1:0]                ch_kind,
  output logic                      ch_rd,
  output logic                      ch_wr,
  output logic [DATA_W-1:0]         ch_wdata,
  input  logic [NUM_CH*DATA_W-1:0]  ch_rdata,
  input  logic [NUM_BLK*DATA_W-1:0] isr_set,
  input  logic [NUM_BLK*DATA_W-1:0] isr_clr,
  output logic [NUM_LINES-1:0]      irq
);
  space_e            space;
  logic [4:0]        off;
  logic [CH_W-1:0]   chan;
  logic [BLK_W-1:0]  blk;
  logic              is_chan;
  regkind_e          kind;
  logic              is_status;
  logic              io_rd, io_wr;
  logic [NUM_BLK*DATA_W-1:0] status_flat;
  logic [NUM_BLK*DATA_W-1:0] imr_flat;
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] id_byte;
  logic [DATA_W-1:0] rd_mux;

  assign space = space_e'(bus_space);
  assign io_rd = bus_rd && (space == SP_IO);
  assign io_wr = bus_wr && (space == SP_IO);

  ouf_bus_decode #(.ADDR_W(ADDR_W), .CH_W(CH_W), .BLK_W(BLK_W)) u_dec (
    .addr(bus_addr), .off(off), .chan(chan), .blk(blk),
    .is_chan(is_chan), .kind(kind), .is_status(is_status)
  );

  // channel access strobes: clock-select writes and command reads are dropped
  always_comb begin
    ch_rd    = io_rd && is_chan && (kind != RK_CMD);
    ch_wr    = io_wr && is_chan && (kind != RK_STAT);
    ch_kind  = kind;
    ch_wdata = bus_wdata;
    ch_sel   = '0;
    if (ch_rd || ch_wr) ch_sel[chan] = 1'b1;
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    ouf_irq_block #(.DATA_W(DATA_W)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(isr_set[b*DATA_W +: DATA_W]),
      .clr_pulse(isr_clr[b*DATA_W +: DATA_W]),
      .mask_we  (io_wr && is_status && (blk == BLK_W'(b))),
      .mask_d   (bus_wdata),
      .status_q (status_flat[b*DATA_W +: DATA_W]),
      .mask_q   (imr_flat[b*DATA_W +: DATA_W])
    );
  end

  ouf_irq_merge #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .status_flat(status_flat), .mask_flat(imr_flat), .irq(irq)
  );

  ouf_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_LEN(ID_LEN)) u_rom (
    .addr(bus_addr), .data(id_byte)
  );

  // vector: reachable from identification or memory space at address 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (bus_wr && (space == SP_ID || space == SP_MEM) &&
                 bus_addr == ADDR_W'(1)) begin
      vec_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (space)
      SP_IO: begin
        if (is_chan && kind != RK_CMD) rd_mux = ch_rdata[chan*DATA_W +: DATA_W];
        else if (is_status)            rd_mux = status_flat[blk*DATA_W +: DATA_W];
      end
      SP_ID:  rd_mux = id_byte;
      SP_ACK: if (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(2)) rd_mux = vec_q;
      SP_MEM: rd_mux = '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ouf_checker.sv
module ouf_checker #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int NUM_BLK = 4,
  parameter int NUM_CH  = 8,
  parameter int NUM_LINES = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_rd,
  input logic                      bus_wr,
  input logic [1:0]                bus_space,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_CH-1:0]         ch_sel,
  input logic                      ch_rd,
  input logic                      ch_wr,
  input logic [NUM_LINES-1:0]      irq,
  input logic [NUM_BLK*DATA_W-1:0] imr_flat,
  input logic [DATA_W-1:0]         vec_q
);
  logic [4:0] c_off;
  logic       c_io;
  assign c_off = bus_addr[4:0] ^ 5'h01;
  assign c_io  = (bus_space == 2'd0);

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel)); // R1

  AST_STROBE_FROM_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd || ch_wr) |-> (c_io && (bus_rd || bus_wr) && ch_sel != '0)); // R1

  AST_NO_CLKSEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_io && c_off[3:0] == 4'h3) |-> !ch_wr); // R2

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_flat == '0) |=> (irq == '0)); // R6

  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && c_io && c_off[3:0] == 4'h5) |=> (bus_rdata == '0)); // R3

  AST_ACK_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_space == 2'd2 && bus_addr != 0 && bus_addr != 2) |=> (bus_rdata == '0)); // R7

  AST_ID_BEYOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_space == 2'd1 && bus_addr >= 24) |=> (bus_rdata == '0)); // R9

  AST_VECTOR_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_space == 2'd1 || bus_space == 2'd3) && bus_addr == 1) |=> $stable(vec_q)); // R8
endmodule

bind octal_uart_frontend ouf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK),
  .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_space(bus_space), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ch_sel(ch_sel), .ch_rd(ch_rd), .ch_wr(ch_wr), .irq(irq),
  .imr_flat(imr_flat), .vec_q(vec_q)
);

// File: tb/octal_uart_frontend_test.sv
module octal_uart_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_space = 2'd0;
  logic [6:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  ch_sel;
  logic [1:0]  ch_kind;
  logic        ch_rd, ch_wr;
  logic [7:0]  ch_wdata;
  logic [63:0] ch_rdata;
  logic [31:0] isr_set = '0, isr_clr = '0;
  logic [1:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  octal_uart_frontend uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_sel(ch_sel), .ch_kind(ch_kind),
    .ch_rd(ch_rd), .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .isr_set(isr_set), .isr_clr(isr_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_expect(input int a);
    logic [7:0] t [12] = '{8'h49, 8'h50, 8'h41, 8'h43, 8'hF0, 8'h22,
                           8'hA1, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hCC};
    return (a < 24) ? t[a/2] : 8'h00;
  endfunction

  task automatic bus_read(input logic [1:0] sp, input logic [6:0] a, output logic [7:0] d);
    bus_space = sp; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] sp, input logic [6:0] a, input logic [7:0] v);
    bus_space = sp; bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] s, input logic [31:0] c);
    isr_set = s; isr_clr = c;
    @(negedge clk);
    isr_set = '0; isr_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 8; i++) ch_rdata[i*8 +: 8] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd2, 7'd0, d);
    chk("R10 vector", d, 0);

    // R1 R3 R11: read sweep over every I/O address
    for (int a = 0; a < 128; a++) begin
      int off, ch, kind;
      logic chan_rd;
      off = (a & 31) ^ 1; ch = a >> 4; kind = (off >> 1) & 3;
      chan_rd = ((off & 8) == 0) && ((off & 1) == 1) && (kind != 2);
      bus_space = 2'd0; bus_addr = 7'(a); bus_rd = 1'b1;
      #1;
      chk("R1 ch_rd", ch_rd, chan_rd);
      chk("R1 ch_sel rd", ch_sel, chan_rd ? (64'd1 << ch) : 64'd0);
      if (chan_rd) chk("R1 ch_kind", ch_kind, kind);
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R3 R11 rdata", bus_rdata, chan_rd ? (64'hA0 + ch) : 64'd0);
    end

    // R1 R2: write sweep, masks kept at zero
    for (int a = 0; a < 128; a++) begin
      int off, ch, kind;
      logic chan_wr;
      off = (a & 31) ^ 1; ch = a >> 4; kind = (off >> 1) & 3;
      chan_wr = ((off & 8) == 0) && ((off & 1) == 1) && (kind != 1);
      bus_space = 2'd0; bus_addr = 7'(a); bus_wr = 1'b1;
      bus_wdata = (off == 11) ? 8'h00 : 8'hFF;
      #1;
      chk("R1 R2 ch_wr", ch_wr, chan_wr);
      chk("R1 R2 ch_sel wr", ch_sel, chan_wr ? (64'd1 << ch) : 64'd0);
      if (chan_wr) chk("R1 ch_wdata", ch_wdata, 8'hFF);
      @(negedge clk);
      bus_wr = 1'b0;
    end
    @(negedge clk);
    chk("R2 irq after writes", irq, 0);

    // R4 R5 R6: every status bit of every block
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] bit1;
        bit1 = 32'd1 << (b*8 + k);
        bus_write(2'd0, 7'(b*32 + 10), 8'(1 << ((k + 1) % 8)));
        pulse(bit1, '0);
        chk("R6 masked-off bit", irq, 0);
        bus_read(2'd0, 7'(b*32 + 10), d);
        chk("R4 status read", d, 64'd1 << k);
        bus_write(2'd0, 7'(b*32 + 10), 8'(1 << k));
        @(negedge clk);
        chk("R5 R6 line", irq, (b < 2) ? 2'b01 : 2'b10);
        pulse('0, bit1);
        chk("R4 R6 cleared", irq, 0);
        pulse(bit1, bit1);
        bus_read(2'd0, 7'(b*32 + 10), d);
        chk("R4 set wins", d, 64'd1 << k);
        pulse('0, bit1);
        bus_write(2'd0, 7'(b*32 + 10), 8'h00);
      end
    end

    // R6: both lines together, pairs merge
    bus_write(2'd0, 7'(32 + 10), 8'h80);
    bus_write(2'd0, 7'(96 + 10), 8'h08);
    pulse(32'h0800_8000, '0);
    chk("R6 both lines", irq, 2'b11);
    pulse('0, 32'hFFFF_FFFF);
    chk("R6 both clear", irq, 0);

    // R7 R8: vector paths
    bus_write(2'd1, 7'd1, 8'h5A);
    bus_read(2'd2, 7'd0, d); chk("R8 R7 ack0", d, 8'h5A);
    bus_read(2'd2, 7'd2, d); chk("R7 ack2", d, 8'h5A);
    for (int a = 0; a < 8; a++) begin
      if (a != 0 && a != 2) begin
        bus_read(2'd2, 7'(a), d);
        chk("R7 other ack", d, 0);
      end
    end
    bus_write(2'd1, 7'd3, 8'h11);
    bus_write(2'd2, 7'd0, 8'h22);
    bus_write(2'd3, 7'd0, 8'h33);
    bus_write(2'd0, 7'd1, 8'h44);
    bus_read(2'd2, 7'd2, d); chk("R8 R7 ignored writes", d, 8'h5A);
    bus_write(2'd3, 7'd1, 8'hC3);
    bus_read(2'd2, 7'd0, d); chk("R8 memory path", d, 8'hC3);
    bus_read(2'd3, 7'd1, d); chk("R8 memory read", d, 0);

    // R9: identification table sweep
    for (int a = 0; a < 40; a++) begin
      bus_read(2'd1, 7'(a), d);
      chk("R9 id byte", d, id_expect(a));
    end

    // R11: data holds without a read
    bus_read(2'd1, 7'd0, d);
    bus_space = 2'd1; bus_addr = 7'd8;
    repeat (2) @(negedge clk);
    chk("R11 hold", bus_rdata, 8'h49);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule